// File: doc/BRIEF.md
# Phase-Frequency Detector with Pump Current Control

This block is the digital front of a phase-locked synthesizer. It compares two streams of edge events, one from the divided reference and one from the divided VCO. Each stream arrives as a single-cycle enable pulse in the system clock domain. The block drives UP and DOWN request lines, and the time each line stays high tracks the phase and frequency error between the two streams. When both lines are high, the detector resets them after a short delay, so that small errors still produce a pulse and the loop has no dead zone.

Alongside the detector, the block holds the control state for an external charge pump. A 3-bit current code sets the pump current to (code + 1) x 0.625 mA, which gives 0.625 mA to 5.0 mA. When fast acquisition is enabled, a write to the divider registers forces the code to its maximum. The boost lasts for a programmable number of reference events and then the programmed code returns, which speeds up settling after a channel change. A standby input silences UP and DOWN, clears the detector and the boost window, and drops the pump output enable so the analog stage can float its output.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: While reset is asserted, up, dn and pump_oe are 0 and pump_code is 0.
- R2: A ref_pulse sampled at a clock edge, with standby low, drives up high after that edge. up then stays high until the detector clears.
- R3: A vco_pulse sampled at a clock edge, with standby low, drives dn high after that edge. dn then stays high until the detector clears.
- R4: After up and dn have both been high for one cycle, both return low on the next edge. A pulse sampled on that same edge sets its own line again.
- R5: If a ref_pulse leads a vco_pulse by k cycles, up stays high for k+1 cycles and dn for 1 cycle. The same holds with the roles of the two pulses swapped.
- R6: code_we loads code_wdata into the programmed code. With no boost active, pump_code shows the new value after that edge.
- R7: A div_wr sampled with fast_en high loads a window of win_len reference events. pump_code reads 7 (all ones) from the next cycle. It returns to the programmed code after the edge that samples the win_len-th ref_pulse. A win_len of 0 gives no boost.
- R8: A div_wr with fast_en low starts no boost. Dropping fast_en during a window returns pump_code to the programmed code one cycle later.
- R9: A div_wr during an active window reloads the window with the current win_len. Counting restarts from the latest write.
- R10: One cycle after standby is sampled high, up, dn and pump_oe are 0 and any boost window is cleared. ref_pulse, vco_pulse and div_wr have no effect while standby is high.
- R11: One cycle after standby is sampled low (and reset released), pump_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | One-cycle event for a divided reference edge |
| vco_pulse | input | 1 | One-cycle event for a divided VCO edge |
| standby | input | 1 | Powers down detector and pump drive |
| code_we | input | 1 | Write strobe for the programmed current code |
| code_wdata | input | CODE_W (3) | Current code to program |
| fast_en | input | 1 | Enables the fast-acquire boost |
| div_wr | input | 1 | Strobe marking a divider register write |
| win_len | input | WIN_W (8) | Boost window length in reference events |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| pump_code | output | CODE_W (3) | Effective current code for the pump |
| pump_oe | output | 1 | Pump output enable; 0 means three-state |

## Verification
Every result of this block lands exactly one clock edge after the edge that samples its cause. This holds for up and dn after a pulse, for the joint clear after the overlap cycle, for pump_code after a code write, divider write, fast_en change or the last counted reference event, and for pump_oe after a standby change. The driver applies each stimulus just after a falling edge and works out the expected outputs for the edge that follows. The monitor samples 1 ns after that rising edge and compares, so every comparison falls in the one cycle where the outcome is due. Long pulse widths and boost windows are covered by runs of consecutive one-cycle expectations, so an early or late transition shows up as a mismatch in a particular cycle.

// File: rtl/pfd_cp_pkg.sv
`timescale 1ns/1ps
package pfd_cp_pkg;

   // Pair of request lines produced by the detector core.
   typedef struct packed {
      logic up;
      logic dn;
   } pfd_drive_t;

   // Pump current code value used while a boost window is open.
   function automatic int unsigned boost_code(input int unsigned width);
      return (1 << width) - 1;
   endfunction

endpackage

// File: rtl/pfd_detector.sv
`timescale 1ns/1ps
module pfd_detector
   import pfd_cp_pkg::*;
#(
   parameter int unsigned CLR_DLY = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_pulse,
   input  logic       vco_pulse,
   input  logic       standby,
   output pfd_drive_t drive
);

   localparam int unsigned HOLD_W = (CLR_DLY > 1) ? $clog2(CLR_DLY) : 1;

   if (CLR_DLY < 1) begin : g_bad_dly
      $error("pfd_detector: CLR_DLY must be at least 1");
   end

   logic up_q;
   logic dn_q;
   logic both;
   logic clr_now;

   assign both = up_q & dn_q;

   // Overlap length before the joint clear.
   if (CLR_DLY == 1) begin : g_clr_imm
      assign clr_now = both;
   end else begin : g_clr_cnt
      logic [HOLD_W-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (standby || !both || clr_now) begin
            hold_q <= '0;
         end else begin
            hold_q <= hold_q + 1'b1;
         end
      end
      assign clr_now = both && (hold_q == HOLD_W'(CLR_DLY - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (standby) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (clr_now) begin
         // Joint clear; an event on this edge restarts its own line.
         up_q <= ref_pulse;
         dn_q <= vco_pulse;
      end else begin
         up_q <= up_q | ref_pulse;
         dn_q <= dn_q | vco_pulse;
      end
   end

   assign drive.up = up_q;
   assign drive.dn = dn_q;

endmodule

// File: rtl/pump_code_ctrl.sv
`timescale 1ns/1ps
module pump_code_ctrl
   import pfd_cp_pkg::*;
#(
   parameter int unsigned CODE_W = 3,
   parameter int unsigned WIN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              ref_pulse,
   input  logic              code_we,
   input  logic [CODE_W-1:0] code_wdata,
   input  logic              fast_en,
   input  logic              div_wr,
   input  logic [WIN_W-1:0]  win_len,
   output logic [CODE_W-1:0] pump_code
);

   localparam logic [CODE_W-1:0] BOOST = CODE_W'(boost_code(CODE_W));

   logic [CODE_W-1:0] code_q;
   logic [WIN_W-1:0]  win_q;
   logic              en_q;
   logic              boost;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         en_q   <= 1'b0;
      end else begin
         if (code_we) begin
            code_q <= code_wdata;
         end
         en_q <= fast_en;
      end
   end

   // Boost window counted in reference events, restarted by divider writes.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (standby) begin
         win_q <= '0;
      end else if (div_wr && fast_en) begin
         win_q <= win_len;
      end else if (ref_pulse && (win_q != '0)) begin
         win_q <= win_q - 1'b1;
      end
   end

   assign boost     = en_q && (win_q != '0);
   assign pump_code = boost ? BOOST : code_q;

endmodule

// File: rtl/pfd_cp_ctrl.sv
`timescale 1ns/1ps
module pfd_cp_ctrl
   import pfd_cp_pkg::*;
#(
   parameter int unsigned CODE_W  = 3,
   parameter int unsigned WIN_W   = 8,
   parameter int unsigned CLR_DLY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_pulse,
   input  logic              vco_pulse,
   input  logic              standby,
   input  logic              code_we,
   input  logic [CODE_W-1:0] code_wdata,
   input  logic              fast_en,
   input  logic              div_wr,
   input  logic [WIN_W-1:0]  win_len,
   output logic              up,
   output logic              dn,
   output logic [CODE_W-1:0] pump_code,
   output logic              pump_oe
);

   if (CODE_W < 1 || CODE_W > 16) begin : g_bad_code
      $error("pfd_cp_ctrl: CODE_W out of range");
   end
   if (WIN_W < 1 || WIN_W > 32) begin : g_bad_win
      $error("pfd_cp_ctrl: WIN_W out of range");
   end

   pfd_drive_t drive;
   logic       oe_q;

   pfd_detector #(
      .CLR_DLY (CLR_DLY)
   ) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_pulse (ref_pulse),
      .vco_pulse (vco_pulse),
      .standby   (standby),
      .drive     (drive)
   );

   pump_code_ctrl #(
      .CODE_W (CODE_W),
      .WIN_W  (WIN_W)
   ) u_code (
      .clk        (clk),
      .rst_n      (rst_n),
      .standby    (standby),
      .ref_pulse  (ref_pulse),
      .code_we    (code_we),
      .code_wdata (code_wdata),
      .fast_en    (fast_en),
      .div_wr     (div_wr),
      .win_len    (win_len),
      .pump_code  (pump_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= 1'b0;
      end else begin
         oe_q <= !standby;
      end
   end

   assign up      = drive.up;
   assign dn      = drive.dn;
   assign pump_oe = oe_q;

endmodule

// File: rtl/pfd_cp_ctrl_chk.sv
`timescale 1ns/1ps
module pfd_cp_ctrl_chk #(
   parameter int unsigned CODE_W  = 3,
   parameter int unsigned WIN_W   = 8,
   parameter int unsigned CLR_DLY = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_pulse,
   input logic              vco_pulse,
   input logic              standby,
   input logic              code_we,
   input logic [CODE_W-1:0] code_wdata,
   input logic              fast_en,
   input logic              div_wr,
   input logic [WIN_W-1:0]  win_len,
   input logic              up,
   input logic              dn,
   input logic [CODE_W-1:0] pump_code,
   input logic              pump_oe
);

   always_comb begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!up && !dn && !pump_oe && pump_code == '0); // R1
      end
   end

   AST_UP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pulse && !standby && !(up && dn)) |=> up); // R2

   AST_DN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (vco_pulse && !standby && !(up && dn)) |=> dn); // R3

   if (CLR_DLY == 1) begin : g_clr_chk
      AST_JOINT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (up && dn && !ref_pulse && !vco_pulse) |=> (!up && !dn)); // R4
   end

   AST_CODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (code_we && !fast_en) |=> (pump_code == $past(code_wdata))); // R6

   AST_BOOST_START: assert property (@(posedge clk) disable iff (!rst_n)
      (div_wr && fast_en && (win_len != '0) && !standby) |=> (pump_code == '1)); // R7

   AST_STBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (!up && !dn && !pump_oe)); // R10

   AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      !standby |=> pump_oe); // R11

endmodule

bind pfd_cp_ctrl pfd_cp_ctrl_chk #(
   .CODE_W  (CODE_W),
   .WIN_W   (WIN_W),
   .CLR_DLY (CLR_DLY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_pulse  (ref_pulse),
   .vco_pulse  (vco_pulse),
   .standby    (standby),
   .code_we    (code_we),
   .code_wdata (code_wdata),
   .fast_en    (fast_en),
   .div_wr     (div_wr),
   .win_len    (win_len),
   .up         (up),
   .dn         (dn),
   .pump_code  (pump_code),
   .pump_oe    (pump_oe)
);

// File: tb/pfd_cp_ctrl_bench.sv
`timescale 1ns/1ps
module pfd_cp_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_pulse = 1'b0;
   logic       vco_pulse = 1'b0;
   logic       standby = 1'b0;
   logic       code_we = 1'b0;
   logic [2:0] code_wdata = 3'd0;
   logic       fast_en = 1'b0;
   logic       div_wr = 1'b0;
   logic [7:0] win_len = 8'd0;
   logic       up;
   logic       dn;
   logic [2:0] pump_code;
   logic       pump_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic       up;
      logic       dn;
      logic [2:0] code;
      logic       oe;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   // Bench-side expectation state, built from the requirements.
   logic       m_up = 1'b0;
   logic       m_dn = 1'b0;
   int         m_win = 0;
   logic       m_en = 1'b0;
   logic [2:0] m_code = 3'd0;

   // Persistent levels used by each step.
   logic       sb_lvl = 1'b0;
   logic       fe_lvl = 1'b0;
   logic [7:0] len_lvl = 8'd0;

   always #2.5 clk = ~clk;

   pfd_cp_ctrl u_pfd_cp_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_pulse  (ref_pulse),
      .vco_pulse  (vco_pulse),
      .standby    (standby),
      .code_we    (code_we),
      .code_wdata (code_wdata),
      .fast_en    (fast_en),
      .div_wr     (div_wr),
      .win_len    (win_len),
      .up         (up),
      .dn         (dn),
      .pump_code  (pump_code),
      .pump_oe    (pump_oe)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
      end
   endtask

   // Driver: apply one cycle of stimulus and queue the outcome due after the next edge.
   task automatic step(input logic r, input logic v, input logic dw,
                       input logic cwe, input logic [2:0] cwd, input string tag);
      exp_t e;
      @(negedge clk);
      ref_pulse  = r;
      vco_pulse  = v;
      standby    = sb_lvl;
      fast_en    = fe_lvl;
      div_wr     = dw;
      win_len    = len_lvl;
      code_we    = cwe;
      code_wdata = cwd;
      if (sb_lvl) begin
         m_up = 1'b0;
         m_dn = 1'b0;
         m_win = 0;
      end else begin
         if (m_up && m_dn) begin
            m_up = r;
            m_dn = v;
         end else begin
            m_up = m_up | r;
            m_dn = m_dn | v;
         end
         if (dw && fe_lvl) m_win = int'(len_lvl);
         else if (r && m_win > 0) m_win = m_win - 1;
      end
      m_en = fe_lvl;
      if (cwe) m_code = cwd;
      e.up   = m_up;
      e.dn   = m_dn;
      e.code = (m_en && m_win != 0) ? 3'd7 : m_code;
      e.oe   = !sb_lvl;
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, tag);
   endtask

   // Monitor: compare one queued item just after each rising edge.
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(up == e.up, e.tag, "up", int'(up), int'(e.up));
         check(dn == e.dn, e.tag, "dn", int'(dn), int'(e.dn));
         check(pump_code == e.code, e.tag, "pump_code", int'(pump_code), int'(e.code));
         check(pump_oe == e.oe, e.tag, "pump_oe", int'(pump_oe), int'(e.oe));
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(200000.0 * 5.0);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all-requirements actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check(up == 1'b0, "R1", "up", int'(up), 0);
      check(dn == 1'b0, "R1", "dn", int'(dn), 0);
      check(pump_code == 3'd0, "R1", "pump_code", int'(pump_code), 0);
      check(pump_oe == 1'b0, "R1", "pump_oe", int'(pump_oe), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: output enabled once standby is seen low
      idle(2, "R11");

      // R2 / R5: reference leads by 3 cycles
      step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R2");
      idle(2, "R5");
      step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R5");
      idle(2, "R4");

      // R3 / R5: VCO leads by 2 cycles
      step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R3");
      idle(1, "R5");
      step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R5");
      idle(2, "R4");

      // R4: simultaneous events, then an event landing on the clear edge
      step(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, "R4");
      idle(1, "R4");
      step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R4");
      step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R4");
      step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R4");
      idle(3, "R4");

      // R6: program the current code
      step(1'b0, 1'b0, 1'b0, 1'b1, 3'd5, "R6");
      idle(1, "R6");
      step(1'b0, 1'b0, 1'b0, 1'b1, 3'd2, "R6");
      idle(1, "R6");

      // R7: boost for three reference events
      fe_lvl = 1'b1;
      len_lvl = 8'd3;
      idle(1, "R7");
      step(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, "R7");
      idle(2, "R7");
      for (int i = 0; i < 3; i++) begin
         step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R7");
         step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R7");
         idle(1, "R7");
      end
      idle(1, "R7");

      // R7: zero-length window gives no boost
      len_lvl = 8'd0;
      step(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, "R7");
      idle(2, "R7");

      // R9: rewrite during a window restarts the count
      len_lvl = 8'd2;
      step(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, "R9");
      step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R9");
      step(1'b0, 1'b1, 1'b1, 1'b0, 3'd0, "R9");
      step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R9");
      step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R9");
      step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R9");
      step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R9");
      idle(2, "R9");

      // R8: fast acquire off means no boost; dropping it ends a window
      fe_lvl = 1'b0;
      len_lvl = 8'd4;
      step(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, "R8");
      idle(2, "R8");
      fe_lvl = 1'b1;
      step(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, "R8");
      idle(1, "R8");
      fe_lvl = 1'b0;
      idle(2, "R8");
      fe_lvl = 1'b1;
      idle(2, "R8");

      // R10: standby silences everything and clears the window
      step(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, "R10");
      step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R10");
      sb_lvl = 1'b1;
      step(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R10");
      step(1'b1, 1'b0, 1'b1, 1'b0, 3'd0, "R10");
      step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R10");
      step(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, "R10");

      // R11: leaving standby restores the enable with no boost left
      sb_lvl = 1'b0;
      idle(3, "R11");
      step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R2");
      idle(1, "R2");
      step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R4");
      idle(2, "R4");

      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      summary();
      $finish;
   end

endmodule